// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Pin-to-Resource Routing

This block is an eight-pin general-purpose I/O port attached to a byte-wide special-function-register bus. Software uses a direction register to make each pin an input or an output. A data register holds the output latch, and reading it returns the live pin levels. The block drives the pad controls: a per-pin output enable, the output value, and one pull-up enable shared by all pins. The pull-ups are on from reset and turn off at the first write to the direction register, so the pins sit at a known level until firmware takes control.

Each pin also has a 3-bit route selector. The selectors sit in four configuration registers, two selectors per register. A selector can feed the synchronized pin level to one of four consumers: the gate/clock input of timer 0, the gate/clock input of timer 1, interrupt request 0 or interrupt request 1. For interrupt routes the level can pass through as is or inverted, so that the interrupt logic downstream sees a falling edge or low level as an active one. When several pins select the same consumer, their contributions are ORed. Each pin input passes through a two-stage synchronizer before it is routed or read back. All four consumer lines come from registers.

Top module: `gpio_route_port`

## Requirements
- R1: After reset, every output enable is 0 and every output value is 0. The pull-up enable is 1 and all four consumer lines are 0. The direction register reads 0xFF and every configuration register reads 0x00.
- R2: A write to address 0x91 loads the direction register, where bit value 0 makes a pin an output and 1 makes it an input. From the next clock, each pad output enable is the inverse of its direction bit, and a read of 0x91 returns the value written.
- R3: The pull-up enable falls in the clock after the first write to 0x91 and stays 0 after any later direction write, including a write of 0xFF.
- R4: A write to address 0x90 loads the output latch, and the pad output value equals the latch from the next clock. A read of 0x90 returns the synchronized pad level for input pins and the latch bit for output pins.
- R5: The configuration registers sit at addresses 0xA0 to 0xA3. Pin 2n uses bits [2:0] of register 0xA0+n and pin 2n+1 uses bits [6:4]. Bits 3 and 7 read as 0.
- R6: Selector values 0 and 1 route the pin to no consumer.
- R7: Selector value 2 drives the pin level onto the timer 0 line, and value 3 drives it onto the timer 1 line.
- R8: Selector value 4 drives the pin level uninverted onto interrupt line 0, and value 5 does the same onto interrupt line 1.
- R9: Selector value 6 drives the inverted pin level onto interrupt line 0, and value 7 does the same onto interrupt line 1.
- R10: The line for a consumer is the OR of the contributions of all pins that select it.
- R11: A change on a pad input reaches the consumer lines on the third rising clock edge after it. The two synchronizer stages take two edges and the output register takes one.
- R12: A write to any address that is not a register of the port changes no register.
- R13: A read-data result is registered. It reflects the address presented before the rising edge and is valid after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr_en | input | 1 | Write strobe, one cycle per write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Registered read data for sfr_addr |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output enable (1 = drive) |
| pad_out | output | 8 | Per-pin output value |
| pad_pullup | output | 1 | Pull-up enable shared by all pads |
| tmr0_gate | output | 1 | Routed timer 0 gate/clock |
| tmr1_gate | output | 1 | Routed timer 1 gate/clock |
| irq0_req | output | 1 | Routed interrupt request 0 |
| irq1_req | output | 1 | Routed interrupt request 1 |

## Verification
The assertions check the register side of the port on every cycle, using only ports. Output enables and output values change only on a write to their own address and then take the written value. The pull-up enable never rises after reset and falls only after a direction write. Selector decoding, the polarity inversion, the OR of several pins, the mixed read-back of the data register and the three-edge input latency depend on configuration state that the ports do not show. The bench scenarios check these by comparing the consumer lines and read data against a reference model.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;

  localparam int SEL_W   = 3;
  localparam int NUM_RES = 4;

  // consumer index within the routed resource vector
  localparam int RES_TMR0 = 0;
  localparam int RES_TMR1 = 1;
  localparam int RES_IRQ0 = 2;
  localparam int RES_IRQ1 = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE_A  = 3'd0,
    SEL_NONE_B  = 3'd1,
    SEL_TMR0    = 3'd2,
    SEL_TMR1    = 3'd3,
    SEL_IRQ0_HI = 3'd4,
    SEL_IRQ1_HI = 3'd5,
    SEL_IRQ0_LO = 3'd6,
    SEL_IRQ1_LO = 3'd7
  } route_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_route_pkg::*;
#(
  parameter int                NUM_PINS  = 8,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h91,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 8'hA0
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               wr_en,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic [NUM_PINS-1:0]                pin_lvl,
  output logic [NUM_PINS-1:0]                oe_q,
  output logic [NUM_PINS-1:0]                latch_q,
  output logic                               pullup_q,
  output logic [NUM_PINS-1:0][SEL_W-1:0]     sel_q,
  output logic [DATA_W-1:0]                  rdata_q
);

  localparam int NUM_CFG = NUM_PINS / 2;
  localparam int HALF_W  = DATA_W / 2;

  logic             hit_data;
  logic             hit_dir;
  logic [NUM_CFG-1:0] hit_cfg;
  logic [DATA_W-1:0]  rd_nxt;

  assign hit_data = (addr == DATA_ADDR);
  assign hit_dir  = (addr == DIR_ADDR);

  for (genvar n = 0; n < NUM_CFG; n++) begin : g_cfg_hit
    assign hit_cfg[n] = (addr == ADDR_W'(CFG_BASE + n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q     <= '0;
      latch_q  <= '0;
      pullup_q <= 1'b1;
      sel_q    <= '0;
    end else if (wr_en) begin
      if (hit_data) latch_q <= wdata[NUM_PINS-1:0];
      if (hit_dir) begin
        oe_q     <= ~wdata[NUM_PINS-1:0];
        pullup_q <= 1'b0;
      end
      for (int n = 0; n < NUM_CFG; n++) begin
        if (hit_cfg[n]) begin
          sel_q[2*n]   <= wdata[SEL_W-1:0];
          sel_q[2*n+1] <= wdata[HALF_W+SEL_W-1:HALF_W];
        end
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (hit_data) rd_nxt[NUM_PINS-1:0] = (pin_lvl & ~oe_q) | (latch_q & oe_q);
    if (hit_dir)  rd_nxt[NUM_PINS-1:0] = ~oe_q;
    for (int n = 0; n < NUM_CFG; n++) begin
      if (hit_cfg[n]) begin
        rd_nxt[SEL_W-1:0]               = sel_q[2*n];
        rd_nxt[HALF_W+SEL_W-1:HALF_W]   = sel_q[2*n+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end

endmodule

// File: rtl/gpio_res_router.sv
module gpio_res_router
  import gpio_route_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PINS-1:0]            pin_lvl,
  input  logic [NUM_PINS-1:0][SEL_W-1:0] sel,
  output logic [NUM_RES-1:0]             res_q
);

  logic [NUM_RES-1:0] contrib [NUM_PINS];
  logic [NUM_RES-1:0] res_nxt;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_RES-1:0] c;
    always_comb begin
      c = '0;
      case (route_sel_e'(sel[p]))
        SEL_TMR0:    c[RES_TMR0] = pin_lvl[p];
        SEL_TMR1:    c[RES_TMR1] = pin_lvl[p];
        SEL_IRQ0_HI: c[RES_IRQ0] = pin_lvl[p];
        SEL_IRQ1_HI: c[RES_IRQ1] = pin_lvl[p];
        SEL_IRQ0_LO: c[RES_IRQ0] = ~pin_lvl[p];
        SEL_IRQ1_LO: c[RES_IRQ1] = ~pin_lvl[p];
        default:     c = '0;
      endcase
    end
    assign contrib[p] = c;
  end

  always_comb begin
    res_nxt = '0;
    for (int p = 0; p < NUM_PINS; p++) res_nxt = res_nxt | contrib[p];
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_nxt;
  end

endmodule

// File: rtl/gpio_route_port.sv
module gpio_route_port
  import gpio_route_pkg::*;
#(
  parameter int                NUM_PINS    = 8,
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h90,
  parameter logic [ADDR_W-1:0] DIR_ADDR    = 8'h91,
  parameter logic [ADDR_W-1:0] CFG_BASE    = 8'hA0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   sfr_addr,
  input  logic                sfr_wr_en,
  input  logic [DATA_W-1:0]   sfr_wdata,
  output logic [DATA_W-1:0]   sfr_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic                pad_pullup,
  output logic                tmr0_gate,
  output logic                tmr1_gate,
  output logic                irq0_req,
  output logic                irq1_req
);

  logic [NUM_PINS-1:0]            pin_lvl;
  logic [NUM_PINS-1:0][SEL_W-1:0] sel;
  logic [NUM_RES-1:0]             res;

  gpio_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_lvl)
  );

  gpio_reg_file #(
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DATA_ADDR (DATA_ADDR),
    .DIR_ADDR  (DIR_ADDR),
    .CFG_BASE  (CFG_BASE)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (sfr_addr),
    .wr_en    (sfr_wr_en),
    .wdata    (sfr_wdata),
    .pin_lvl  (pin_lvl),
    .oe_q     (pad_oe),
    .latch_q  (pad_out),
    .pullup_q (pad_pullup),
    .sel_q    (sel),
    .rdata_q  (sfr_rdata)
  );

  gpio_res_router #(
    .NUM_PINS (NUM_PINS)
  ) u_router (
    .clk     (clk),
    .rst     (rst),
    .pin_lvl (pin_lvl),
    .sel     (sel),
    .res_q   (res)
  );

  assign tmr0_gate = res[RES_TMR0];
  assign tmr1_gate = res[RES_TMR1];
  assign irq0_req  = res[RES_IRQ0];
  assign irq1_req  = res[RES_IRQ1];

endmodule

// File: rtl/gpio_route_port_chk.sv
module gpio_route_port_chk #(
  parameter int                NUM_PINS  = 8,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h91
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   sfr_addr,
  input logic                sfr_wr_en,
  input logic [DATA_W-1:0]   sfr_wdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic                pad_pullup
);

  logic wr_dir;
  logic wr_dat;
  assign wr_dir = sfr_wr_en && (sfr_addr == DIR_ADDR);
  assign wr_dat = sfr_wr_en && (sfr_addr == DATA_ADDR);

  AST_OE_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> pad_oe == ~$past(sfr_wdata[NUM_PINS-1:0])); // R2
  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_dir |=> $stable(pad_oe)); // R12
  AST_PULLUP_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
    !$rose(pad_pullup)); // R3
  AST_PULLUP_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(pad_pullup) |-> $past(wr_dir)); // R3
  AST_OUT_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_dat |=> pad_out == $past(sfr_wdata[NUM_PINS-1:0])); // R4
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_dat |=> $stable(pad_out)); // R12

endmodule

bind gpio_route_port gpio_route_port_chk #(
  .NUM_PINS  (NUM_PINS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .DATA_ADDR (DATA_ADDR),
  .DIR_ADDR  (DIR_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sfr_addr   (sfr_addr),
  .sfr_wr_en  (sfr_wr_en),
  .sfr_wdata  (sfr_wdata),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pad_pullup (pad_pullup)
);

// File: tb/gpio_route_port_tb.sv
module gpio_route_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'h90;
  localparam logic [7:0] A_DIR  = 8'h91;
  localparam logic [7:0] A_CFG  = 8'hA0;

  localparam int K_RD = 0, K_RES = 1, K_OE = 2, K_OUT = 3, K_PU = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = '0;
  logic       sfr_wr_en = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic [7:0] sfr_rdata;
  logic [7:0] pad_in = 8'hA5;
  logic [7:0] pad_oe, pad_out;
  logic       pad_pullup, tmr0_gate, tmr1_gate, irq0_req, irq1_req;

  gpio_route_port u_dut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pullup(pad_pullup),
    .tmr0_gate(tmr0_gate), .tmr1_gate(tmr1_gate),
    .irq0_req(irq0_req), .irq1_req(irq1_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_dir = 8'hFF;
  logic [7:0] m_lat = 8'h00;
  logic [2:0] m_sel [8] = '{default: 3'd0};

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] actual(int k);
    case (k)
      K_RD:    return sfr_rdata;
      K_RES:   return {4'b0, irq1_req, irq0_req, tmr1_gate, tmr0_gate};
      K_OE:    return pad_oe;
      K_OUT:   return pad_out;
      default: return {7'b0, pad_pullup};
    endcase
  endfunction

  // consumer vector: bit0 tmr0, bit1 tmr1, bit2 irq0, bit3 irq1
  function automatic logic [7:0] model_res(logic [7:0] pins);
    logic [7:0] r;
    r = '0;
    for (int p = 0; p < 8; p++) begin
      case (m_sel[p])
        3'd2: r[0] = r[0] | pins[p];
        3'd3: r[1] = r[1] | pins[p];
        3'd4: r[2] = r[2] | pins[p];
        3'd5: r[3] = r[3] | pins[p];
        3'd6: r[2] = r[2] | ~pins[p];
        3'd7: r[3] = r[3] | ~pins[p];
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic [7:0] model_cfg(int n);
    return {1'b0, m_sel[2*n+1], 1'b0, m_sel[2*n]};
  endfunction

  // monitor: compares scheduled items just after the edge they fall due on
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = actual(it.kind);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_at(int dly, int kind, logic [7:0] exp, string tag);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr_en = 1'b1;
    @(negedge clk);
    sfr_wr_en = 1'b0;
    if (a == A_DATA) m_lat = d;
    else if (a == A_DIR) m_dir = d;
    else if (a >= A_CFG && a < A_CFG + 8'd4) begin
      m_sel[2*(a-A_CFG)]   = d[2:0];
      m_sel[2*(a-A_CFG)+1] = d[6:4];
    end
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    sfr_addr = a;
    expect_at(1, K_RD, exp, tag);
    @(negedge clk);
  endtask

  task automatic set_sel(int p, logic [2:0] v);
    logic [2:0] lo, hi;
    lo = (p % 2 == 0) ? v : m_sel[p-1];
    hi = (p % 2 == 1) ? v : m_sel[p+1];
    wr(8'(A_CFG + p/2), {1'b0, hi, 1'b0, lo});
  endtask

  task automatic clear_sel();
    for (int n = 0; n < 4; n++) wr(8'(A_CFG + n), 8'h00);
  endtask

  task automatic res_check(logic [7:0] pins, string tag);
    pad_in = pins;
    repeat (4) @(negedge clk);
    expect_at(1, K_RES, model_res(pins), tag);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    expect_at(1, K_OE, 8'h00, "R1 oe");
    expect_at(1, K_OUT, 8'h00, "R1 out");
    expect_at(1, K_PU, 8'h01, "R1 pullup");
    expect_at(1, K_RES, 8'h00, "R1 consumers");
    @(negedge clk);
    rd(A_DIR, 8'hFF, "R1 dir read");
    for (int n = 0; n < 4; n++) rd(8'(A_CFG + n), 8'h00, "R1 cfg read");
    rd(A_DATA, 8'hA5, "R4 all-input read");          // R13 registered read too

    // R4 data latch, R3 pull-up survives data write
    wr(A_DATA, 8'h3C);
    expect_at(1, K_OUT, 8'h3C, "R4 pad_out");
    expect_at(1, K_PU, 8'h01, "R3 pullup before dir write");
    @(negedge clk);

    // R2 direction, R3 first direction write
    wr(A_DIR, 8'hF0);
    expect_at(1, K_OE, 8'h0F, "R2 oe");
    expect_at(1, K_PU, 8'h00, "R3 pullup off");
    @(negedge clk);
    rd(A_DIR, 8'hF0, "R2 dir read");
    rd(A_DATA, 8'hAC, "R4 mixed read");
    wr(A_DIR, 8'hFF);
    expect_at(1, K_PU, 8'h00, "R3 stays off");
    expect_at(1, K_OE, 8'h00, "R2 all input");
    @(negedge clk);

    // R12 unmapped writes
    wr(8'h8F, 8'h00);
    wr(8'hA4, 8'h77);
    wr(8'h92, 8'h00);
    expect_at(1, K_OE, 8'h00, "R12 oe unchanged");
    expect_at(1, K_OUT, 8'h3C, "R12 out unchanged");
    @(negedge clk);
    rd(A_DIR, 8'hFF, "R12 dir unchanged");
    for (int n = 0; n < 4; n++) rd(8'(A_CFG + n), 8'h00, "R12 cfg unchanged");

    // R5 configuration layout
    wr(A_CFG, 8'hFF);
    rd(A_CFG, 8'h77, "R5 reserved bits zero");
    wr(A_CFG + 8'd1, 8'h52);
    rd(A_CFG + 8'd1, 8'h52, "R5 readback");
    rd(A_CFG, model_cfg(0), "R5 neighbour intact");
    clear_sel();

    // R6 no route
    set_sel(0, 3'd0); set_sel(1, 3'd1);
    res_check(8'hFF, "R6 sel0/1 none");
    res_check(8'h00, "R6 sel0/1 none low");

    // R7 timers
    set_sel(0, 3'd2); set_sel(1, 3'd3);
    res_check(8'h01, "R7 tmr0");
    res_check(8'h02, "R7 tmr1");
    clear_sel();

    // R8 interrupts true polarity
    set_sel(2, 3'd4); set_sel(3, 3'd5);
    res_check(8'h0C, "R8 irq high");
    res_check(8'h04, "R8 irq0 only");
    clear_sel();

    // R9 interrupts inverted polarity
    set_sel(4, 3'd6); set_sel(5, 3'd7);
    res_check(8'h00, "R9 inverted low");
    res_check(8'h30, "R9 inverted high");
    res_check(8'h10, "R9 irq1 only");
    clear_sel();

    // R10 OR of several pins
    set_sel(6, 3'd2); set_sel(7, 3'd2);
    set_sel(2, 3'd4); set_sel(4, 3'd6);
    res_check(8'h40, "R10 or pin6");
    res_check(8'h80, "R10 or pin7");
    res_check(8'h10, "R10 or none");
    res_check(8'h04, "R10 irq0 both");
    res_check(8'hC4, "R10 mixed");
    clear_sel();

    // R11 latency
    set_sel(0, 3'd2);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    pad_in = 8'h01;
    expect_at(2, K_RES, 8'h00, "R11 not before third edge");
    expect_at(3, K_RES, 8'h01, "R11 at third edge");
    repeat (5) @(negedge clk);

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule